// File: doc/BRIEF.md
# Privilege and Trap Entry Unit

This unit keeps the privilege state of a processor core and decides, each cycle, whether control must leave the current instruction stream. It tracks one mode bit (user or kernel), an interrupt-enable flag, a base/limit window for user memory references, and the program counter and mode to come back to. Fetch and data addresses issued in user mode are checked against the window. Privileged operations issued in user mode are refused. System calls and external interrupt lines are accepted. The selected cause is turned into a redirect program counter taken from a fixed vector set.

The surrounding pipeline supplies the current PC, the fetch and data addresses with their valid flags, a 3-bit privileged-operation code with a write operand, a system-call flag and the interrupt lines. It then follows the redirect strobe. All outputs are registered. A request presented before a rising edge shows its effect on the outputs right after that edge.

Top module: `priv_trap_unit`

## Requirements
- R1: After reset, mode_o is 0 (kernel; 1 means user), interrupts are disabled, base and limit are both 0 (so every user reference is out of range), and redirect_valid_o, bounds_fault_o and halted_o are 0.
- R2: In user mode, a valid fetch address outside base <= addr < base+limit raises bounds_fault_o and redirects to 0x00080000 (illegal address) on the next edge. An in-range address causes neither.
- R3: In user mode, a valid data address outside the window raises bounds_fault_o and redirects to 0x00100000 (memory violation).
- R4: In kernel mode, fetch and data addresses are not checked: no fault and no redirect.
- R5: Any nonzero operation code in user mode (1 set mode, 2 interrupts on, 3 interrupts off, 4 load base, 5 load limit, 6 halt, 7 return) redirects to 0x00100480 (illegal instruction) and has no other effect.
- R6: A system-call request redirects to 0x00123010.
- R7: When several causes coincide, the winner is taken in this order: fetch fault, data fault, illegal instruction, system call, interrupt.
- R8: Trap entry sets mode_o to kernel in the same cycle that redirect_valid_o rises. It clears the interrupt-enable flag and saves the PC, the mode and the enable flag.
- R9: Interrupt lines are ignored while interrupts are disabled. When they are enabled, the lowest-numbered active line n redirects to 0x00002000 + 16*n.
- R10: Return (code 7) in kernel mode redirects to the saved PC and restores the saved mode and interrupt-enable flag.
- R11: In kernel mode, codes 1 to 6 take effect: code 1 sets the mode from wdata_i[0], codes 2/3 enable/disable interrupts, codes 4/5 load base/limit from wdata_i, and code 6 raises halted_o until the next trap entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_i | input | AW | PC of the current instruction |
| ifetch_i | input | 1 | Fetch address valid |
| iaddr_i | input | AW | Fetch address |
| dacc_i | input | 1 | Data address valid |
| daddr_i | input | AW | Data address |
| priv_op_i | input | 3 | Privileged operation code |
| wdata_i | input | AW | Operand for mode/base/limit writes |
| syscall_i | input | 1 | System-call request |
| irq_i | input | NIRQ | External interrupt lines |
| redirect_valid_o | output | 1 | Redirect strobe |
| redirect_pc_o | output | AW | Redirect target |
| mode_o | output | 1 | 0 kernel, 1 user |
| bounds_fault_o | output | 1 | Out-of-window user reference seen |
| halted_o | output | 1 | Halt state |

## Verification
The bench sweeps fetch and data addresses across and beyond a small window. An off-by-one at base or at base+limit would flag the first or last legal word, or would miss the first illegal one. It drives all sixteen combinations of the synchronous causes, each with an interrupt pending. A swapped priority then shows up as the wrong vector, and a missing mask shows up as an interrupt that wins over a real fault. It also issues every privileged code from user mode and checks afterwards that the window, the enable flag and the halt state are unchanged. A return that fails to restore the enable flag is caught by an interrupt that stays ignored after the return.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_SET_MODE = 3'd1,
    OP_IE_ON    = 3'd2,
    OP_IE_OFF   = 3'd3,
    OP_LD_BASE  = 3'd4,
    OP_LD_LIMIT = 3'd5,
    OP_HALT     = 3'd6,
    OP_RETURN   = 3'd7
  } priv_op_e;

  localparam int unsigned NUM_CAUSE = 4;

  // index is also priority: lower wins
  typedef enum logic [1:0] {
    CAUSE_FETCH = 2'd0,
    CAUSE_DATA  = 2'd1,
    CAUSE_INSN  = 2'd2,
    CAUSE_SCALL = 2'd3
  } cause_e;

  localparam logic MODE_KERNEL = 1'b0;
  localparam logic MODE_USER   = 1'b1;
endpackage

// File: rtl/priv_bounds_chk.sv
module priv_bounds_chk #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] limit_i,
  input  logic [AW-1:0] addr_i,
  output logic          in_range_o
);
  logic [AW:0] top_w;
  assign top_w      = {1'b0, base_i} + {1'b0, limit_i};
  assign in_range_o = (addr_i >= base_i) && ({1'b0, addr_i} < top_w);
endmodule

// File: rtl/priv_cause_arb.sv
module priv_cause_arb
  import priv_trap_pkg::*;
#(
  parameter int unsigned   AW           = 32,
  parameter int unsigned   NIRQ         = 4,
  parameter logic [AW-1:0] VEC_FETCH    = AW'(32'h0008_0000),
  parameter logic [AW-1:0] VEC_DATA     = AW'(32'h0010_0000),
  parameter logic [AW-1:0] VEC_INSN     = AW'(32'h0010_0480),
  parameter logic [AW-1:0] VEC_SCALL    = AW'(32'h0012_3010),
  parameter logic [AW-1:0] IRQ_BASE     = AW'(32'h0000_2000),
  parameter int unsigned   IRQ_SHIFT    = 4
) (
  input  logic [NUM_CAUSE-1:0] cause_i,
  input  logic [NIRQ-1:0]      irq_i,
  input  logic                 ie_i,
  output logic                 enter_o,
  output logic                 irq_take_o,
  output logic [AW-1:0]        vec_o
);
  localparam int unsigned IW = (NIRQ > 1) ? $clog2(NIRQ) : 1;

  logic            sync_take;
  cause_e          csel;
  logic [NIRQ-1:0] irq_live;
  logic [IW-1:0]   isel;
  logic [AW-1:0]   cvec;

  assign irq_live = irq_i & {NIRQ{ie_i}};

  always_comb begin
    sync_take = 1'b0;
    csel      = CAUSE_FETCH;
    for (int i = NUM_CAUSE - 1; i >= 0; i--) begin
      if (cause_i[i]) begin
        sync_take = 1'b1;
        csel      = cause_e'(i[1:0]);
      end
    end
    isel = '0;
    for (int j = NIRQ - 1; j >= 0; j--) begin
      if (irq_live[j]) isel = j[IW-1:0];
    end
    case (csel)
      CAUSE_FETCH: cvec = VEC_FETCH;
      CAUSE_DATA:  cvec = VEC_DATA;
      CAUSE_INSN:  cvec = VEC_INSN;
      default:     cvec = VEC_SCALL;
    endcase
  end

  assign irq_take_o = !sync_take && (|irq_live);
  assign enter_o    = sync_take || irq_take_o;
  assign vec_o      = sync_take ? cvec : IRQ_BASE + (AW'(isel) << IRQ_SHIFT);
endmodule

// File: rtl/priv_trap_unit.sv
module priv_trap_unit
  import priv_trap_pkg::*;
#(
  parameter int unsigned   AW        = 32,
  parameter int unsigned   NIRQ      = 4,
  parameter logic [AW-1:0] VEC_FETCH = AW'(32'h0008_0000),
  parameter logic [AW-1:0] VEC_DATA  = AW'(32'h0010_0000),
  parameter logic [AW-1:0] VEC_INSN  = AW'(32'h0010_0480),
  parameter logic [AW-1:0] VEC_SCALL = AW'(32'h0012_3010),
  parameter logic [AW-1:0] IRQ_BASE  = AW'(32'h0000_2000),
  parameter int unsigned   IRQ_SHIFT = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   pc_i,
  input  logic            ifetch_i,
  input  logic [AW-1:0]   iaddr_i,
  input  logic            dacc_i,
  input  logic [AW-1:0]   daddr_i,
  input  logic [2:0]      priv_op_i,
  input  logic [AW-1:0]   wdata_i,
  input  logic            syscall_i,
  input  logic [NIRQ-1:0] irq_i,
  output logic            redirect_valid_o,
  output logic [AW-1:0]   redirect_pc_o,
  output logic            mode_o,
  output logic            bounds_fault_o,
  output logic            halted_o
);
  localparam int unsigned NREF = 2;  // 0 fetch, 1 data

  logic          mode_q, ie_q, halted_q, redir_valid_q, fault_q;
  logic          saved_mode_q, saved_ie_q;
  logic [AW-1:0] base_q, limit_q, saved_pc_q, redir_pc_q;

  logic [NREF-1:0]      ref_valid, in_range, ref_fault;
  logic [NREF-1:0][AW-1:0] ref_addr;
  logic                 user, bad_insn, enter, irq_take, rtt_take;
  logic [NUM_CAUSE-1:0] causes;
  logic [AW-1:0]        vec;
  priv_op_e             op;

  assign user      = (mode_q == MODE_USER);
  assign op        = priv_op_e'(priv_op_i);
  assign ref_valid = {dacc_i, ifetch_i};
  assign ref_addr  = {daddr_i, iaddr_i};

  for (genvar g = 0; g < NREF; g++) begin : g_ref
    priv_bounds_chk #(.AW(AW)) u_chk (
      .base_i     (base_q),
      .limit_i    (limit_q),
      .addr_i     (ref_addr[g]),
      .in_range_o (in_range[g])
    );
    assign ref_fault[g] = user && ref_valid[g] && !in_range[g];
  end

  assign bad_insn = user && (op != OP_NONE);
  assign causes   = {syscall_i, bad_insn, ref_fault[1], ref_fault[0]};

  priv_cause_arb #(
    .AW(AW), .NIRQ(NIRQ),
    .VEC_FETCH(VEC_FETCH), .VEC_DATA(VEC_DATA),
    .VEC_INSN(VEC_INSN), .VEC_SCALL(VEC_SCALL),
    .IRQ_BASE(IRQ_BASE), .IRQ_SHIFT(IRQ_SHIFT)
  ) u_arb (
    .cause_i    (causes),
    .irq_i      (irq_i),
    .ie_i       (ie_q),
    .enter_o    (enter),
    .irq_take_o (irq_take),
    .vec_o      (vec)
  );

  assign rtt_take = !enter && !user && (op == OP_RETURN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q        <= MODE_KERNEL;
      ie_q          <= 1'b0;
      halted_q      <= 1'b0;
      base_q        <= '0;
      limit_q       <= '0;
      saved_pc_q    <= '0;
      saved_mode_q  <= MODE_KERNEL;
      saved_ie_q    <= 1'b0;
      redir_valid_q <= 1'b0;
      redir_pc_q    <= '0;
      fault_q       <= 1'b0;
    end else begin
      redir_valid_q <= enter || rtt_take;
      fault_q       <= |ref_fault;
      if (enter) begin
        saved_pc_q   <= pc_i;
        saved_mode_q <= mode_q;
        saved_ie_q   <= ie_q;
        mode_q       <= MODE_KERNEL;
        ie_q         <= 1'b0;
        halted_q     <= 1'b0;
        redir_pc_q   <= vec;
      end else if (rtt_take) begin
        redir_pc_q <= saved_pc_q;
        mode_q     <= saved_mode_q;
        ie_q       <= saved_ie_q;
      end else if (!user) begin
        case (op)
          OP_SET_MODE: mode_q   <= wdata_i[0];
          OP_IE_ON:    ie_q     <= 1'b1;
          OP_IE_OFF:   ie_q     <= 1'b0;
          OP_LD_BASE:  base_q   <= wdata_i;
          OP_LD_LIMIT: limit_q  <= wdata_i;
          OP_HALT:     halted_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign redirect_valid_o = redir_valid_q;
  assign redirect_pc_o    = redir_pc_q;
  assign mode_o           = mode_q;
  assign bounds_fault_o   = fault_q;
  assign halted_o         = halted_q;
endmodule

// File: rtl/priv_trap_unit_chk.sv
module priv_trap_unit_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          enter,
  input logic          irq_take,
  input logic          rtt_take,
  input logic          ie_q,
  input logic          mode_o,
  input logic          redirect_valid_o,
  input logic          bounds_fault_o,
  input logic          saved_mode_q,
  input logic [AW-1:0] saved_pc_q,
  input logic [AW-1:0] pc_i
);
  assert_entry_kernel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter |=> (redirect_valid_o && mode_o == 1'b0 && !ie_q));

  assert_entry_saves_pc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter |=> (saved_pc_q == $past(pc_i)));

  assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_q |-> !irq_take);

  assert_kernel_unchecked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 1'b0) |=> !bounds_fault_o);

  assert_single_redirect_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({enter, rtt_take}));

  assert_return_mode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rtt_take |=> (redirect_valid_o && mode_o == $past(saved_mode_q)));
endmodule

bind priv_trap_unit priv_trap_unit_chk #(.AW(AW)) u_priv_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .enter            (enter),
  .irq_take         (irq_take),
  .rtt_take         (rtt_take),
  .ie_q             (ie_q),
  .mode_o           (mode_o),
  .redirect_valid_o (redirect_valid_o),
  .bounds_fault_o   (bounds_fault_o),
  .saved_mode_q     (saved_mode_q),
  .saved_pc_q       (saved_pc_q),
  .pc_i             (pc_i)
);

// File: tb/priv_trap_unit_test.sv
module priv_trap_unit_test;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] V_FETCH = 32'h0008_0000;
  localparam logic [31:0] V_DATA  = 32'h0010_0000;
  localparam logic [31:0] V_INSN  = 32'h0010_0480;
  localparam logic [31:0] V_SCALL = 32'h0012_3010;
  localparam logic [31:0] V_IRQ   = 32'h0000_2000;
  localparam int WBASE = 16, WLIM = 8;

  logic clk = 0, rst_n = 0;
  logic [31:0] pc, iaddr, daddr, wdata;
  logic ifetch, dacc, syscall;
  logic [2:0] op;
  logic [3:0] irq;
  logic rv, mode, bf, halted;
  logic [31:0] rpc;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_trap_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .ifetch_i(ifetch), .iaddr_i(iaddr),
    .dacc_i(dacc), .daddr_i(daddr), .priv_op_i(op), .wdata_i(wdata),
    .syscall_i(syscall), .irq_i(irq), .redirect_valid_o(rv), .redirect_pc_o(rpc),
    .mode_o(mode), .bounds_fault_o(bf), .halted_o(halted)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    pc = 32'h100; iaddr = 0; daddr = 0; wdata = 0;
    ifetch = 0; dacc = 0; syscall = 0; op = 0; irq = 0;
  endtask

  task automatic cyc();
    @(posedge clk); #1; clr();
  endtask

  task automatic kop(input logic [2:0] code, input logic [31:0] d);
    op = code; wdata = d; cyc();
  endtask

  task automatic trapped(input string tag, input logic [31:0] v);
    chk({tag, " strobe"}, 32'(rv), 1);
    chk({tag, " vector"}, rpc, v);
    chk({tag, " kernel"}, 32'(mode), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    clr();
    #(CLK_PERIOD*2); #1;
    // R1 reset state
    chk("R1 mode", 32'(mode), 0);
    chk("R1 redirect", 32'(rv), 0);
    chk("R1 fault", 32'(bf), 0);
    chk("R1 halted", 32'(halted), 0);
    rst_n = 1;
    irq = 4'hF; cyc();
    chk("R1 irq disabled", 32'(rv), 0);
    kop(3'd1, 1);
    chk("R1 user entered", 32'(mode), 1);
    ifetch = 1; iaddr = 0; cyc();
    trapped("R1 zero limit", V_FETCH);

    // R11 window load; R2 fetch sweep; R6 syscall exit
    kop(3'd4, WBASE); kop(3'd5, WLIM);
    for (int a = 0; a < 40; a++) begin
      automatic bit bad = !(a >= WBASE && a < WBASE + WLIM);
      kop(3'd1, 1);
      ifetch = 1; iaddr = a; cyc();
      chk("R2 fault flag", 32'(bf), 32'(bad));
      if (bad) trapped("R2 fetch", V_FETCH);
      else begin
        chk("R2 no redirect", 32'(rv), 0);
        chk("R2 still user", 32'(mode), 1);
        syscall = 1; cyc();
        trapped("R6 syscall", V_SCALL);
      end
    end
    // R3 data sweep
    for (int a = 0; a < 40; a++) begin
      automatic bit bad = !(a >= WBASE && a < WBASE + WLIM);
      kop(3'd1, 1);
      dacc = 1; daddr = a; cyc();
      chk("R3 fault flag", 32'(bf), 32'(bad));
      if (bad) trapped("R3 data", V_DATA);
      else begin syscall = 1; cyc(); end
    end
    // R4 kernel skips checks
    ifetch = 1; iaddr = 999; dacc = 1; daddr = 0; cyc();
    chk("R4 no fault", 32'(bf), 0);
    chk("R4 no redirect", 32'(rv), 0);

    // R5 every code refused in user mode
    for (int c = 1; c < 8; c++) begin
      kop(3'd1, 1);
      op = 3'(c); wdata = 0; cyc();
      trapped("R5 refused", V_INSN);
      chk("R5 no halt", 32'(halted), 0);
    end
    kop(3'd1, 1);
    ifetch = 1; iaddr = WBASE + WLIM - 1; irq = 4'h1; cyc();
    chk("R5 window kept", 32'(bf), 0);
    chk("R5 ie kept off", 32'(rv), 0);
    syscall = 1; cyc();

    // R7 priority over all sync combinations, interrupt pending
    for (int m = 0; m < 16; m++) begin
      logic [31:0] ev;
      kop(3'd2, 0); kop(3'd1, 1);
      ifetch = 1; iaddr = m[0] ? 0 : WBASE;
      dacc = 1;   daddr = m[1] ? 0 : WBASE + 1;
      op = m[2] ? 3'd3 : 3'd0;
      syscall = m[3]; irq = 4'b0100;
      cyc();
      ev = m[0] ? V_FETCH : m[1] ? V_DATA : m[2] ? V_INSN : m[3] ? V_SCALL : V_IRQ + 32;
      trapped("R7 priority", ev);
    end

    // R8 entry saves state; R10 return restores
    kop(3'd2, 0); kop(3'd1, 1);
    pc = 32'h4444; syscall = 1; cyc();
    trapped("R8 entry", V_SCALL);
    irq = 4'h1; cyc();
    chk("R8 ie cleared", 32'(rv), 0);
    kop(3'd7, 0);
    chk("R10 strobe", 32'(rv), 1);
    chk("R10 pc", rpc, 32'h4444);
    chk("R10 mode", 32'(mode), 1);
    pc = 32'h5555; irq = 4'h1; cyc();
    trapped("R9 irq0", V_IRQ);
    kop(3'd7, 0);
    chk("R10 irq pc", rpc, 32'h5555);
    irq = 4'b1010; cyc();
    trapped("R9 lowest line", V_IRQ + 16);

    // R11 halt and interrupt disable
    kop(3'd6, 0);
    chk("R11 halted", 32'(halted), 1);
    syscall = 1; cyc();
    chk("R11 halt cleared", 32'(halted), 0);
    kop(3'd2, 0); kop(3'd3, 0);
    irq = 4'hF; cyc();
    chk("R11 ie off", 32'(rv), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule